// File: doc/BRIEF.md
# Multi-Bank GPIO Controller with Edge-Detect Interrupts

This block is a register-mapped controller for 85 general-purpose pins held in three 32-bit banks. The third bank has only 21 live bits. For each pin the block provides:

- a direction bit that drives the pad output enable;
- an output latch that changes only through write-one set and write-one clear registers;
- a synchronised level that can be read back;
- separate enables for rising edges and for falling edges;
- a sticky edge-status bit that is cleared by writing 1 to it.

Each pin also stores a 2-bit function-select field and presents it to the pin multiplexer outside the block. A value of zero selects plain GPIO.

Pin inputs pass through a two-flop synchroniser. An edge is detected by comparing the synchronised level with its value one cycle earlier. Pin 0 and pin 1 each drive a dedicated interrupt line from their own status bit. The status bits of every other pin are ORed onto one shared line. Software services the shared line by reading the status banks and writing back the bits it has handled.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: The 85 pins occupy three 32-bit banks (pins 0-31, 32-63, 64-84). In the third bank, bits 21 to 31 of every register read as zero and ignore writes.
- R2: A rising edge on a pin whose rising-edge enable is 1 sets that pin's status bit. A pin that toggles with both enables at 0 sets no status bit. The status bit reads as set from the third rising clock edge after the input changes.
- R3: A falling edge on a pin whose falling-edge enable is 1 sets its status bit. A rising edge on a pin that has only its falling-edge enable set leaves the status bit clear.
- R4: Status bits are sticky. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R5: `irq_pin0` equals the status bit of pin 0 and `irq_pin1` equals the status bit of pin 1. Neither depends on any other pin.
- R6: `irq_shared` is the OR of the status bits of pins 2 to 84.
- R7: Writing 1s to a bank's set register drives those output-latch bits high, and writing 1s to its clear register drives them low. Zero bits in either write change nothing. `pin_out` shows the latches, and reading either register returns the latch.
- R8: A direction bit of 1 makes the pin an output (`pin_oe` high), and 0 makes it an input. The level register returns the synchronised pin input whatever the direction.
- R9: Each pin has a 2-bit function field. Pins 16k to 16k+15 are packed into function register k, with pin 16k+j at bits 2j+1:2j. The fields appear on `pin_fn`, where pin p uses bits 2p+1:2p. Function register 5 holds only pins 80 to 84, so its bits 10 to 31 read as zero.
- R10: After reset, all of the following are zero: direction, output latches, edge enables, status, function fields, `rd_data` and all three interrupt lines.
- R11: If a clearing write to a status bit and a new enabled edge on that bit act in the same cycle, the bit stays set.
- R12: The word address is {group[2:0], index[2:0]}. The groups are: 0 level (read only), 1 direction, 2 set, 3 clear, 4 rising enable, 5 falling enable, 6 status, 7 function. The index selects the bank (0 to 2) or the function register (0 to 5). A write takes effect at the clock edge where `wr_en` is sampled high. `rd_data` is loaded at the edge where `rd_en` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 6 | Word address {group, index} |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| pin_in | input | 85 | Pad input levels (asynchronous) |
| pin_out | output | 85 | Output latch values |
| pin_oe | output | 85 | Output enables from the direction registers |
| pin_fn | output | 170 | Function-select fields, 2 bits per pin |
| irq_pin0 | output | 1 | Interrupt from pin 0 status |
| irq_pin1 | output | 1 | Interrupt from pin 1 status |
| irq_shared | output | 1 | OR of the status of pins 2 to 84 |

## Verification
Edge detection is driven with a rising-only enable, a falling-only enable, both enables together, and a pin toggled with no enable. Together these separate a polarity swap, a missing enable gate and an any-change detector. Pins 0, 1, 5, 40 and 84 are each driven alone, so a pin routed to the wrong interrupt line shows up on a line that should stay quiet. A clearing write is timed to land on the same edge as a new edge event, which separates edge-wins precedence from clear-wins. Writes of all ones to the third bank and to the last function register show whether the unimplemented bits were masked.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

   localparam int GRP_W  = 3;
   localparam int IDX_W  = 3;
   localparam int ADDR_W = GRP_W + IDX_W;

   typedef enum logic [GRP_W-1:0] {
      GRP_LEVEL = 3'd0,
      GRP_DIR   = 3'd1,
      GRP_SET   = 3'd2,
      GRP_CLR   = 3'd3,
      GRP_RISE  = 3'd4,
      GRP_FALL  = 3'd5,
      GRP_STAT  = 3'd6,
      GRP_FN    = 3'd7
   } reg_grp_e;

   function automatic logic [ADDR_W-1:0] reg_addr(input reg_grp_e grp, input int unsigned idx);
      logic [IDX_W-1:0] idx_l;
      idx_l = IDX_W'(idx);
      return {grp, idx_l};
   endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_sync needs at least two stages");
   end

   logic [WIDTH-1:0] chain_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
      end else begin
         chain_q[0] <= async_i;
         for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
      end
   end

   assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank #(
   parameter int BANK_W = 32,
   parameter int LIVE   = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BANK_W-1:0] lvl_i,
   input  logic              wr_dir,
   input  logic              wr_set,
   input  logic              wr_clr,
   input  logic              wr_rise,
   input  logic              wr_fall,
   input  logic              wr_stat,
   input  logic [BANK_W-1:0] wr_data,
   output logic [BANK_W-1:0] dir_o,
   output logic [BANK_W-1:0] out_o,
   output logic [BANK_W-1:0] rise_o,
   output logic [BANK_W-1:0] fall_o,
   output logic [BANK_W-1:0] stat_o,
   output logic [BANK_W-1:0] lvl_o
);

   localparam logic [BANK_W-1:0] LIVE_MASK = BANK_W'((64'd1 << LIVE) - 64'd1);

   if (LIVE < 1 || LIVE > BANK_W) begin : g_bad_live
      $error("gpio_bank live bit count out of range");
   end

   logic [BANK_W-1:0] dir_q, out_q, rise_q, fall_q, stat_q, prev_q;
   logic [BANK_W-1:0] lvl_m, wdat_m, rise_evt, fall_evt, edge_evt, clr_bits;

   always_comb begin
      lvl_m    = lvl_i & LIVE_MASK;
      wdat_m   = wr_data & LIVE_MASK;
      rise_evt = lvl_m & ~prev_q & rise_q;
      fall_evt = ~lvl_m & prev_q & fall_q;
      edge_evt = (rise_evt | fall_evt) & LIVE_MASK;
      clr_bits = wr_stat ? wdat_m : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q  <= '0;
         out_q  <= '0;
         rise_q <= '0;
         fall_q <= '0;
         stat_q <= '0;
         prev_q <= '0;
      end else begin
         prev_q <= lvl_m;
         if (wr_dir)  dir_q  <= wdat_m;
         if (wr_rise) rise_q <= wdat_m;
         if (wr_fall) fall_q <= wdat_m;
         if (wr_set)       out_q <= out_q | wdat_m;
         else if (wr_clr)  out_q <= out_q & ~wdat_m;
         // a fresh edge takes precedence over a clear in the same cycle
         stat_q <= (stat_q & ~clr_bits) | edge_evt;
      end
   end

   assign dir_o  = dir_q;
   assign out_o  = out_q;
   assign rise_o = rise_q;
   assign fall_o = fall_q;
   assign stat_o = stat_q;
   assign lvl_o  = lvl_m;

endmodule

// File: rtl/gpio_fn_store.sv
module gpio_fn_store #(
   parameter int NUM_PINS = 85,
   parameter int BANK_W   = 32,
   parameter int FN_W     = 2,
   parameter int IDX_W    = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_i,
   input  logic [IDX_W-1:0]         idx_i,
   input  logic [BANK_W-1:0]        wr_data,
   output logic [BANK_W-1:0]        rd_o,
   output logic [NUM_PINS*FN_W-1:0] pin_fn_o
);

   localparam int FPR      = BANK_W / FN_W;
   localparam int NUM_REGS = (NUM_PINS + FPR - 1) / FPR;

   logic [BANK_W-1:0] fn_q [NUM_REGS];

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      localparam int LEFT = NUM_PINS - r * FPR;
      localparam int LIVE = (LEFT >= FPR) ? FPR : LEFT;
      localparam logic [BANK_W-1:0] MASK = BANK_W'((64'd1 << (LIVE * FN_W)) - 64'd1);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                fn_q[r] <= '0;
         else if (wr_i && idx_i == IDX_W'(r))       fn_q[r] <= wr_data & MASK;
      end
   end

   always_comb begin
      rd_o = '0;
      for (int r = 0; r < NUM_REGS; r++)
         if (idx_i == IDX_W'(r)) rd_o = fn_q[r];
   end

   always_comb begin
      for (int p = 0; p < NUM_PINS; p++)
         pin_fn_o[p*FN_W +: FN_W] = fn_q[p / FPR][(p % FPR) * FN_W +: FN_W];
   end

endmodule

// File: rtl/gpio_irq_merge.sv
module gpio_irq_merge #(
   parameter int PAD_W     = 96,
   parameter int DEDICATED = 2
) (
   input  logic [PAD_W-1:0]     stat_i,
   output logic [DEDICATED-1:0] irq_ded_o,
   output logic                 irq_shared_o
);

   if (DEDICATED < 1 || DEDICATED >= PAD_W) begin : g_bad_ded
      $error("gpio_irq_merge dedicated line count out of range");
   end

   assign irq_ded_o    = stat_i[DEDICATED-1:0];
   assign irq_shared_o = |stat_i[PAD_W-1:DEDICATED];

endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl #(
   parameter int NUM_PINS    = 85,
   parameter int BANK_W      = 32,
   parameter int FN_W        = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic                     rd_en,
   input  logic [5:0]               addr,
   input  logic [BANK_W-1:0]        wr_data,
   output logic [BANK_W-1:0]        rd_data,
   input  logic [NUM_PINS-1:0]      pin_in,
   output logic [NUM_PINS-1:0]      pin_out,
   output logic [NUM_PINS-1:0]      pin_oe,
   output logic [NUM_PINS*FN_W-1:0] pin_fn,
   output logic                     irq_pin0,
   output logic                     irq_pin1,
   output logic                     irq_shared
);
   import gpio_edge_pkg::*;

   localparam int NUM_BANKS   = (NUM_PINS + BANK_W - 1) / BANK_W;
   localparam int PAD_W       = NUM_BANKS * BANK_W;
   localparam int FPR         = BANK_W / FN_W;
   localparam int NUM_FN_REGS = (NUM_PINS + FPR - 1) / FPR;
   localparam int DEDICATED   = 2;

   if (BANK_W % FN_W != 0)          begin : g_bad_fn   $error("FN_W must divide BANK_W");          end
   if (BANK_W > 63)                 begin : g_bad_bw   $error("BANK_W must not exceed 63");        end
   if (NUM_BANKS > (1 << IDX_W))    begin : g_bad_nb   $error("too many banks for the index");     end
   if (NUM_FN_REGS > (1 << IDX_W))  begin : g_bad_nf   $error("too many function registers");      end
   if (NUM_PINS <= DEDICATED)       begin : g_bad_np   $error("need more pins than dedicated");    end

   reg_grp_e         grp;
   logic [IDX_W-1:0] idx;
   assign grp = reg_grp_e'(addr[ADDR_W-1:IDX_W]);
   assign idx = addr[IDX_W-1:0];

   logic [NUM_PINS-1:0] pin_sync;
   logic [PAD_W-1:0]    lvl_pad;

   gpio_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (pin_in),
      .sync_o  (pin_sync)
   );
   assign lvl_pad = PAD_W'(pin_sync);

   logic [BANK_W-1:0] dir_b  [NUM_BANKS];
   logic [BANK_W-1:0] out_b  [NUM_BANKS];
   logic [BANK_W-1:0] rise_b [NUM_BANKS];
   logic [BANK_W-1:0] fall_b [NUM_BANKS];
   logic [BANK_W-1:0] stat_b [NUM_BANKS];
   logic [BANK_W-1:0] lvl_b  [NUM_BANKS];

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      localparam int LEFT = NUM_PINS - b * BANK_W;
      localparam int LIVE = (LEFT >= BANK_W) ? BANK_W : LEFT;
      logic hit;
      assign hit = wr_en && (idx == IDX_W'(b));

      gpio_bank #(.BANK_W(BANK_W), .LIVE(LIVE)) u_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .lvl_i   (lvl_pad[b*BANK_W +: BANK_W]),
         .wr_dir  (hit && grp == GRP_DIR),
         .wr_set  (hit && grp == GRP_SET),
         .wr_clr  (hit && grp == GRP_CLR),
         .wr_rise (hit && grp == GRP_RISE),
         .wr_fall (hit && grp == GRP_FALL),
         .wr_stat (hit && grp == GRP_STAT),
         .wr_data (wr_data),
         .dir_o   (dir_b[b]),
         .out_o   (out_b[b]),
         .rise_o  (rise_b[b]),
         .fall_o  (fall_b[b]),
         .stat_o  (stat_b[b]),
         .lvl_o   (lvl_b[b])
      );
   end

   logic [BANK_W-1:0] fn_rd;

   gpio_fn_store #(.NUM_PINS(NUM_PINS), .BANK_W(BANK_W), .FN_W(FN_W), .IDX_W(IDX_W)) u_fn (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_i     (wr_en && grp == GRP_FN),
      .idx_i    (idx),
      .wr_data  (wr_data),
      .rd_o     (fn_rd),
      .pin_fn_o (pin_fn)
   );

   logic [PAD_W-1:0] stat_flat;
   always_comb begin
      for (int b = 0; b < NUM_BANKS; b++) stat_flat[b*BANK_W +: BANK_W] = stat_b[b];
      for (int p = 0; p < NUM_PINS; p++) begin
         pin_oe[p]  = dir_b[p / BANK_W][p % BANK_W];
         pin_out[p] = out_b[p / BANK_W][p % BANK_W];
      end
   end

   logic [DEDICATED-1:0] irq_ded;

   gpio_irq_merge #(.PAD_W(PAD_W), .DEDICATED(DEDICATED)) u_irq (
      .stat_i       (stat_flat),
      .irq_ded_o    (irq_ded),
      .irq_shared_o (irq_shared)
   );
   assign irq_pin0 = irq_ded[0];
   assign irq_pin1 = irq_ded[1];

   logic [BANK_W-1:0] rd_mux;
   always_comb begin
      rd_mux = '0;
      if (grp == GRP_FN) begin
         rd_mux = fn_rd;
      end else begin
         for (int b = 0; b < NUM_BANKS; b++) begin
            if (idx == IDX_W'(b)) begin
               unique case (grp)
                  GRP_LEVEL:         rd_mux = lvl_b[b];
                  GRP_DIR:           rd_mux = dir_b[b];
                  GRP_SET, GRP_CLR:  rd_mux = out_b[b];
                  GRP_RISE:          rd_mux = rise_b[b];
                  GRP_FALL:          rd_mux = fall_b[b];
                  GRP_STAT:          rd_mux = stat_b[b];
                  default:           rd_mux = '0;
               endcase
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rd_data <= '0;
      else if (rd_en) rd_data <= rd_mux;
   end

endmodule

// File: rtl/gpio_edge_ctrl_chk.sv
module gpio_edge_ctrl_chk #(
   parameter int NUM_PINS = 85,
   parameter int BANK_W   = 32
) (
   input logic                clk,
   input logic                rst_n,
   input logic                wr_en,
   input logic                rd_en,
   input logic [5:0]          addr,
   input logic [BANK_W-1:0]   wr_data,
   input logic [BANK_W-1:0]   rd_data,
   input logic [NUM_PINS-1:0] pin_out,
   input logic [NUM_PINS-1:0] pin_oe,
   input logic                irq_pin0
);
   import gpio_edge_pkg::*;

   localparam int NUM_BANKS = (NUM_PINS + BANK_W - 1) / BANK_W;
   localparam int TOP_LIVE  = NUM_PINS - (NUM_BANKS - 1) * BANK_W;
   localparam logic [5:0] A_SET0  = {GRP_SET,  3'd0};
   localparam logic [5:0] A_CLR0  = {GRP_CLR,  3'd0};
   localparam logic [5:0] A_DIR0  = {GRP_DIR,  3'd0};
   localparam logic [5:0] A_STAT0 = {GRP_STAT, 3'd0};

   AST_SET_DRIVES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_SET0) |=> ((pin_out[BANK_W-1:0] & $past(wr_data)) == $past(wr_data))); // R7

   AST_CLR_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_CLR0) |=> ((pin_out[BANK_W-1:0] & $past(wr_data)) == '0)); // R7

   AST_SET_KEEPS_ZERO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_SET0) |=>
      ((pin_out[BANK_W-1:0] & ~$past(wr_data)) == ($past(pin_out[BANK_W-1:0]) & ~$past(wr_data)))); // R7

   AST_DIR_TO_OE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_DIR0) |=> (pin_oe[BANK_W-1:0] == $past(wr_data))); // R8

   AST_IRQ0_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_pin0 && !(wr_en && addr == A_STAT0 && wr_data[0])) |=> irq_pin0); // R4

   if (TOP_LIVE < BANK_W) begin : g_top
      AST_TOP_BANK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_en && addr[5:3] != GRP_FN && addr[2:0] == 3'(NUM_BANKS - 1)) |=>
         ((rd_data >> TOP_LIVE) == '0)); // R1
   end

endmodule

bind gpio_edge_ctrl gpio_edge_ctrl_chk #(.NUM_PINS(NUM_PINS), .BANK_W(BANK_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .rd_en    (rd_en),
   .addr     (addr),
   .wr_data  (wr_data),
   .rd_data  (rd_data),
   .pin_out  (pin_out),
   .pin_oe   (pin_oe),
   .irq_pin0 (irq_pin0)
);

// File: tb/gpio_edge_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_edge_ctrl_tb;

   localparam int NP = 85;
   // address = {group, index}
   localparam logic [5:0] LVL1 = 6'o01, DIR0 = 6'o10, DIR1 = 6'o11, DIR2 = 6'o12;
   localparam logic [5:0] SET0 = 6'o20, SET1 = 6'o21, CLR0 = 6'o30;
   localparam logic [5:0] RISE0 = 6'o40, RISE2 = 6'o42, FALL0 = 6'o50, FALL1 = 6'o51;
   localparam logic [5:0] STAT0 = 6'o60, STAT1 = 6'o61, STAT2 = 6'o62, FN0 = 6'o70, FN5 = 6'o75;

   logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
   logic [5:0] addr = '0;
   logic [31:0] wr_data = '0, rd_data;
   logic [NP-1:0] pin_in = '0, pin_out, pin_oe;
   logic [2*NP-1:0] pin_fn;
   logic irq_pin0, irq_pin1, irq_shared;
   int checks = 0, errors = 0;

   always #2.5 clk = ~clk;

   gpio_edge_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wr_data(wr_data), .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out),
      .pin_oe(pin_oe), .pin_fn(pin_fn), .irq_pin0(irq_pin0), .irq_pin1(irq_pin1),
      .irq_shared(irq_shared)
   );

   task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [31:0] d);
      @(negedge clk); rd_en = 1'b1; addr = a;
      @(negedge clk); rd_en = 1'b0; d = rd_data;
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      chk(pin_oe == '0 && pin_out == '0, "R10 oe/out", {pin_oe, pin_out}, 0);
      chk(pin_fn == '0, "R10 fn", pin_fn, 0);
      chk({irq_pin0, irq_pin1, irq_shared} == 3'b0, "R10 irqs", {irq_pin0, irq_pin1, irq_shared}, 0);
      rd(DIR0, d);  chk(d == 0, "R10 dir0", d, 0);
      rd(STAT2, d); chk(d == 0, "R10 stat2", d, 0);
      rd(RISE0, d); chk(d == 0, "R10 rise0", d, 0);
   endtask

   task automatic t_out_latch();
      logic [31:0] d;
      wr(SET0, 32'hF0F0_0001);
      chk(pin_out[31:0] == 32'hF0F0_0001, "R7 set", pin_out[31:0], 32'hF0F0_0001);
      wr(CLR0, 32'h00F0_0001);
      chk(pin_out[31:0] == 32'hF000_0000, "R7 clear", pin_out[31:0], 32'hF000_0000);
      wr(SET0, 32'h0);
      rd(SET0, d); chk(d == 32'hF000_0000, "R7 zero set no effect", d, 32'hF000_0000);
      wr(SET1, 32'h8000_0000);
      chk(pin_out[63:32] == 32'h8000_0000, "R7 bank1 set", pin_out[63:32], 32'h8000_0000);
   endtask

   task automatic t_dir_level();
      logic [31:0] d;
      wr(DIR1, 32'hA5A5_0F0F);
      chk(pin_oe[63:32] == 32'hA5A5_0F0F, "R8 oe", pin_oe[63:32], 32'hA5A5_0F0F);
      pin_in[63:32] = 32'h1234_5678;
      settle();
      rd(LVL1, d); chk(d == 32'h1234_5678, "R8 level", d, 32'h1234_5678);
   endtask

   task automatic t_top_bank();
      logic [31:0] d;
      wr(DIR2, 32'hFFFF_FFFF);
      rd(DIR2, d); chk(d == 32'h001F_FFFF, "R1 dir2 upper zero", d, 32'h001F_FFFF);
      chk(pin_oe[84:64] == 21'h1F_FFFF, "R1 oe top", pin_oe[84:64], 21'h1F_FFFF);
      wr(RISE2, 32'hFFFF_FFFF);
      rd(RISE2, d); chk(d == 32'h001F_FFFF, "R1 rise2 upper zero", d, 32'h001F_FFFF);
      wr(RISE2, 32'h0);
   endtask

   task automatic t_rise();
      logic [31:0] d;
      wr(RISE0, 32'h1);
      @(negedge clk); pin_in[0] = 1'b1;
      @(posedge clk); @(posedge clk); @(negedge clk);
      chk(irq_pin0 == 1'b0, "R2 not before third edge", irq_pin0, 0);
      @(negedge clk);
      chk(irq_pin0 == 1'b1, "R2 rise sets at third edge", irq_pin0, 1);
      chk(irq_pin1 == 1'b0 && irq_shared == 1'b0, "R5 pin0 only", {irq_pin1, irq_shared}, 0);
      pin_in[0] = 1'b0; pin_in[3] = 1'b1; settle();
      pin_in[3] = 1'b0; settle();
      rd(STAT0, d); chk(d == 32'h1, "R2 disabled pin3 no status", d, 1);
   endtask

   task automatic t_fall();
      logic [31:0] d;
      wr(FALL0, 32'h2);
      @(negedge clk); pin_in[1] = 1'b1; settle();
      chk(irq_pin1 == 1'b0, "R3 rise ignored on fall enable", irq_pin1, 0);
      pin_in[1] = 1'b0; settle();
      chk(irq_pin1 == 1'b1, "R5 irq1 from pin1 fall", irq_pin1, 1);
      rd(STAT0, d); chk(d == 32'h3, "R3 stat after fall", d, 3);
   endtask

   task automatic t_w1c();
      logic [31:0] d;
      wr(STAT0, 32'h0);
      rd(STAT0, d); chk(d == 32'h3, "R4 zero write keeps", d, 3);
      wr(STAT0, 32'h2);
      chk(irq_pin1 == 1'b0 && irq_pin0 == 1'b1, "R4 clear bit1 only", {irq_pin0, irq_pin1}, 2'b10);
      wr(STAT0, 32'h1);
      chk(irq_pin0 == 1'b0, "R4 clear bit0", irq_pin0, 0);
   endtask

   task automatic t_race();
      logic [31:0] d;
      wr(RISE0, 32'h21); wr(FALL0, 32'h22);
      @(negedge clk); pin_in[5] = 1'b1; settle();
      chk(irq_shared == 1'b1 && irq_pin0 == 1'b0, "R6 pin5 on shared", {irq_shared, irq_pin0}, 2'b10);
      @(negedge clk); pin_in[5] = 1'b0;
      @(posedge clk); @(posedge clk);
      @(negedge clk); wr_en = 1'b1; addr = STAT0; wr_data = 32'h20;
      @(negedge clk); wr_en = 1'b0;
      rd(STAT0, d); chk(d == 32'h20, "R11 edge wins over clear", d, 32'h20);
      wr(STAT0, 32'h20);
      rd(STAT0, d); chk(d == 32'h0 && irq_shared == 1'b0, "R4 plain clear", d, 0);
   endtask

   task automatic t_shared();
      logic [31:0] d;
      wr(RISE2, 32'h0010_0000);
      @(negedge clk); pin_in[84] = 1'b1; settle();
      chk(irq_shared && !irq_pin0 && !irq_pin1, "R6 pin84 shared", {irq_shared, irq_pin0, irq_pin1}, 3'b100);
      rd(STAT2, d); chk(d == 32'h0010_0000, "R6 stat2", d, 32'h0010_0000);
      wr(STAT2, 32'h0010_0000);
      chk(irq_shared == 1'b0, "R6 shared drops", irq_shared, 0);
      wr(FALL1, 32'h100);
      @(negedge clk); pin_in[40] = 1'b1; settle();
      chk(irq_shared == 1'b0, "R3 pin40 rise ignored", irq_shared, 0);
      pin_in[40] = 1'b0; settle();
      rd(STAT1, d); chk(d == 32'h100 && irq_shared, "R6 pin40 fall", {irq_shared, d}, {1'b1, 32'h100});
      wr(STAT1, 32'h100);
      chk(irq_shared == 1'b0, "R6 shared clear", irq_shared, 0);
   endtask

   task automatic t_fn();
      logic [31:0] d;
      wr(FN0, 32'h6);
      chk(pin_fn[1:0] == 2'd2 && pin_fn[3:2] == 2'd1, "R9 fn fields", pin_fn[3:0], 4'h6);
      wr(FN5, 32'hFFFF_FFFF);
      rd(FN5, d); chk(d == 32'h3FF, "R9 fn5 live bits", d, 32'h3FF);
      chk(pin_fn[169:160] == 10'h3FF, "R9 pins80-84 fn", pin_fn[169:160], 10'h3FF);
      rd(FN0, d); chk(d == 32'h6, "R12 fn readback", d, 6);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_out_latch();
      t_dir_level();
      t_top_bank();
      t_rise();
      t_fall();
      t_w1c();
      t_race();
      t_shared();
      t_fn();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule